// File: doc/BRIEF.md
# Bidirectional Dual-Port Mailbox Memory

This block lets two agents exchange messages through shared storage. It holds two separate stores, each of 128 words by 8 bits. Each store carries traffic in one fixed direction. Side A fills the A-to-B store and side B drains it. Side B fills the B-to-A store and side A drains it. Each side has its own clock, reset, chip select, write enable, output enable, address bus and data buses, and works independently of the other side.

Each side decodes its own controls. With select and write enable active, the side writes the store it owns. With select and output enable active and write enable inactive, the side reads the store it receives from, and the word appears one clock later on its own clock. If a write and a read hit the same word of one store on the same edge, the read returns the word as it was before the write, and a collision flag is raised next to that read result.

Top module: `mailbox_dp`

## Requirements
- R1: A word written from side A at index i (0..127) is returned by a later read from side B at index i.
- R2: A word written from side B at index i is returned by a later read from side A at index i.
- R3: Only address bits [6:0] select a word. Address bit 7 has no effect on writes or reads.
- R4: A write happens only when select and write enable are both 1. With select at 0 the store is unchanged. A write cycle produces no read result: valid is 0 on the next cycle.
- R5: A read is issued when select=1, output enable=1 and write enable=0. On the next edge of that side's clock, rdata holds the word and rvalid is 1.
- R6: Whenever no read was issued on the previous edge, and during and after reset, rdata is 0, rvalid is 0 and the collision flag is 0.
- R7: If a write from one side and a read from the other side target the same word on the same clock edge, the read returns the old contents and the reader's collision flag is 1 with that result. A read and a write to different words give flag 0.
- R8: The two stores are independent. A write from a side never changes what that same side reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A reset, active low |
| sel_a | input | 1 | Side A select |
| wen_a | input | 1 | Side A write enable |
| oen_a | input | 1 | Side A output enable |
| addr_a | input | 8 | Side A address, bit 7 ignored |
| wdata_a | input | 8 | Side A write data into A-to-B store |
| rdata_a | output | 8 | Side A read data from B-to-A store |
| rvalid_a | output | 1 | Side A read result valid |
| coll_a | output | 1 | Side A read collided with a side B write |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B reset, active low |
| sel_b | input | 1 | Side B select |
| wen_b | input | 1 | Side B write enable |
| oen_b | input | 1 | Side B output enable |
| addr_b | input | 8 | Side B address, bit 7 ignored |
| wdata_b | input | 8 | Side B write data into B-to-A store |
| rdata_b | output | 8 | Side B read data from A-to-B store |
| rvalid_b | output | 1 | Side B read result valid |
| coll_b | output | 1 | Side B read collided with a side A write |

## Verification
The hardest case to reach is a same-word collision. It needs a write on one side and a read on the other to land on the very same clock edge. The stimulus runs both clocks in phase and drives both sides from a single task between edges, so both requests meet at the same edge. The task then checks that the reader saw the stale word with the flag set, and that a follow-up read sees the new word with the flag clear. It does this in both directions, and again with different words as a negative case.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic sel, input logic wen, input logic oen);
    if (sel && wen)        return OP_WRITE;
    else if (sel && oen)   return OP_READ;
    else                   return OP_IDLE;
  endfunction
endpackage

// File: rtl/mailbox_port_ctl.sv
module mailbox_port_ctl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 7
) (
  input  logic              sel,
  input  logic              wen,
  input  logic              oen,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_req,
  output logic              rd_req,
  output logic [IDX_W-1:0]  idx
);
  import mailbox_pkg::*;

  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  port_op_e op;
  logic     unused_hi;

  assign op        = decode_op(sel, wen, oen);
  assign wr_req    = (op == OP_WRITE);
  assign rd_req    = (op == OP_READ);
  assign idx       = word_index(addr);
  assign unused_hi = ^addr[ADDR_W-1:IDX_W];

  always_comb begin
    AST_NO_DUAL_REQ: assert (!(wr_req && rd_req)); // R4
  end
endmodule

// File: rtl/mailbox_store.sv
module mailbox_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              coll
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              same_word_hit;

  assign same_word_hit = rd_en && wr_en && (waddr == raddr);

  always_ff @(posedge wclk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      coll   <= 1'b0;
    end else begin
      rdata  <= rd_en ? mem[raddr] : '0;
      rvalid <= rd_en;
      coll   <= same_word_hit;
    end
  end

  AST_READ_GIVES_VALID: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_en |=> rvalid); // R5
  AST_IDLE_IS_ZERO: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_en |=> (!rvalid && rdata == '0 && !coll)); // R6
  AST_COLL_WITH_RESULT: assert property (@(posedge rclk) disable iff (!rrst_n)
    coll |-> rvalid); // R7
endmodule

// File: rtl/mailbox_dp.sv
module mailbox_dp #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              sel_a,
  input  logic              wen_a,
  input  logic              oen_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] rdata_a,
  output logic              rvalid_a,
  output logic              coll_a,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              sel_b,
  input  logic              wen_b,
  input  logic              oen_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] rdata_b,
  output logic              rvalid_b,
  output logic              coll_b
);
  logic             a_wr, a_rd, b_wr, b_rd;
  logic [IDX_W-1:0] a_idx, b_idx;

  mailbox_port_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl_a (
    .sel(sel_a), .wen(wen_a), .oen(oen_a), .addr(addr_a),
    .wr_req(a_wr), .rd_req(a_rd), .idx(a_idx)
  );

  mailbox_port_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl_b (
    .sel(sel_b), .wen(wen_b), .oen(oen_b), .addr(addr_b),
    .wr_req(b_wr), .rd_req(b_rd), .idx(b_idx)
  );

  // A-to-B direction: written on clk_a, read on clk_b
  mailbox_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_a2b (
    .wclk(clk_a), .wr_en(a_wr), .waddr(a_idx), .wdata(wdata_a),
    .rclk(clk_b), .rrst_n(rst_b_n), .rd_en(b_rd), .raddr(b_idx),
    .rdata(rdata_b), .rvalid(rvalid_b), .coll(coll_b)
  );

  // B-to-A direction: written on clk_b, read on clk_a
  mailbox_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_b2a (
    .wclk(clk_b), .wr_en(b_wr), .waddr(b_idx), .wdata(wdata_b),
    .rclk(clk_a), .rrst_n(rst_a_n), .rd_en(a_rd), .raddr(a_idx),
    .rdata(rdata_a), .rvalid(rvalid_a), .coll(coll_a)
  );

  AST_A_WRITE_NO_RESULT: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (sel_a && wen_a) |=> !rvalid_a); // R4
  AST_B_WRITE_NO_RESULT: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (sel_b && wen_b) |=> !rvalid_b); // R4
endmodule

// File: tb/mailbox_dp_tb_top.sv
`timescale 1ns/1ps
module mailbox_dp_tb_top;
  logic       clk_a = 1'b0, clk_b = 1'b0;
  logic       rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic       sel_a = 0, wen_a = 0, oen_a = 0, sel_b = 0, wen_b = 0, oen_b = 0;
  logic [7:0] addr_a = 0, wdata_a = 0, addr_b = 0, wdata_b = 0;
  logic [7:0] rdata_a, rdata_b;
  logic       rvalid_a, rvalid_b, coll_a, coll_b;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] ref_ab [128];
  logic [7:0] ref_ba [128];

  always #2.5 clk_a = ~clk_a;
  always #2.5 clk_b = ~clk_b;

  mailbox_dp dut_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .sel_a(sel_a), .wen_a(wen_a), .oen_a(oen_a),
    .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a), .rvalid_a(rvalid_a), .coll_a(coll_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .sel_b(sel_b), .wen_b(wen_b), .oen_b(oen_b),
    .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b), .rvalid_b(rvalid_b), .coll_b(coll_b)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    sel_a = 0; wen_a = 0; oen_a = 0; sel_b = 0; wen_b = 0; oen_b = 0;
  endtask

  // one cycle: drive at negedge, edge captures, next negedge is the result point
  task automatic write_a(input logic [7:0] ad, input logic [7:0] d);
    sel_a = 1; wen_a = 1; oen_a = 0; addr_a = ad; wdata_a = d;
    @(negedge clk_a);
    idle_all();
  endtask

  task automatic write_b(input logic [7:0] ad, input logic [7:0] d);
    sel_b = 1; wen_b = 1; oen_b = 0; addr_b = ad; wdata_b = d;
    @(negedge clk_a);
    idle_all();
  endtask

  task automatic read_b_chk(input string tag, input logic [7:0] ad, input logic [7:0] exp);
    sel_b = 1; wen_b = 0; oen_b = 1; addr_b = ad;
    @(negedge clk_a);
    idle_all();
    check({tag, " rdata_b"}, rdata_b, exp);
    check({tag, " rvalid_b"}, {7'd0, rvalid_b}, 8'd1);
  endtask

  task automatic read_a_chk(input string tag, input logic [7:0] ad, input logic [7:0] exp);
    sel_a = 1; wen_a = 0; oen_a = 1; addr_a = ad;
    @(negedge clk_a);
    idle_all();
    check({tag, " rdata_a"}, rdata_a, exp);
    check({tag, " rvalid_a"}, {7'd0, rvalid_a}, 8'd1);
  endtask

  task automatic t_reset();
    check("R6 reset rdata_a", rdata_a, 8'h00);
    check("R6 reset rdata_b", rdata_b, 8'h00);
    check("R6 reset flags", {4'd0, rvalid_a, rvalid_b, coll_a, coll_b}, 8'h00);
  endtask

  task automatic t_fill_a2b();
    for (int i = 0; i < 128; i++) begin
      ref_ab[i] = 8'(i * 7 + 3) ^ 8'h5A;
      write_a(8'(i), ref_ab[i]);
    end
    for (int i = 0; i < 128; i++) read_b_chk("R1 a2b", 8'(i), ref_ab[i]);
  endtask

  task automatic t_fill_b2a();
    for (int i = 0; i < 128; i++) begin
      ref_ba[i] = 8'(i * 13 + 1) ^ 8'hA5;
      write_b(8'(i), ref_ba[i]);
    end
    for (int i = 127; i >= 0; i--) read_a_chk("R2 b2a", 8'(i), ref_ba[i]);
  endtask

  task automatic t_independent();
    write_a(8'd5, ~ref_ba[5]); ref_ab[5] = ~ref_ba[5];
    read_a_chk("R8 own write a", 8'd5, ref_ba[5]);
    write_b(8'd9, ~ref_ab[9]); ref_ba[9] = ~ref_ab[9];
    read_b_chk("R8 own write b", 8'd9, ref_ab[9]);
  endtask

  task automatic t_addr_msb();
    write_a(8'h8A, 8'hC3); ref_ab[10] = 8'hC3;
    read_b_chk("R3 low index", 8'h0A, 8'hC3);
    read_b_chk("R3 high alias", 8'h8A, 8'hC3);
    write_b(8'h0B, 8'h3C); ref_ba[11] = 8'h3C;
    read_a_chk("R3 alias a", 8'h8B, 8'h3C);
  endtask

  task automatic t_write_rules();
    sel_a = 0; wen_a = 1; addr_a = 8'd20; wdata_a = 8'hEE;
    @(negedge clk_a);
    idle_all();
    read_b_chk("R4 no select", 8'd20, ref_ab[20]);
    sel_a = 1; wen_a = 1; oen_a = 1; addr_a = 8'd21; wdata_a = 8'h77;
    @(negedge clk_a);
    idle_all(); ref_ab[21] = 8'h77;
    check("R4 write gives no rvalid", {7'd0, rvalid_a}, 8'd0);
    check("R6 write gives zero rdata", rdata_a, 8'h00);
    read_b_chk("R4 write with oen", 8'd21, 8'h77);
  endtask

  task automatic t_idle_outputs();
    sel_b = 1; oen_b = 0; wen_b = 0; addr_b = 8'd3;
    sel_a = 0; oen_a = 1; wen_a = 0; addr_a = 8'd3;
    @(negedge clk_a);
    idle_all();
    check("R6 no oen rdata_b", rdata_b, 8'h00);
    check("R6 no sel rdata_a", rdata_a, 8'h00);
    check("R6 idle valids", {6'd0, rvalid_a, rvalid_b}, 8'h00);
    read_a_chk("R5 read after idle", 8'd3, ref_ba[3]);
    @(negedge clk_a);
    check("R6 after read rdata_a", rdata_a, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] old;
    old = ref_ab[30];
    sel_a = 1; wen_a = 1; addr_a = 8'd30; wdata_a = ~old;
    sel_b = 1; oen_b = 1; addr_b = 8'd30;
    @(negedge clk_a);
    idle_all(); ref_ab[30] = ~old;
    check("R7 old data b", rdata_b, old);
    check("R7 coll_b set", {6'd0, coll_b, rvalid_b}, 8'h03);
    read_b_chk("R7 new data b", 8'd30, ~old);
    check("R7 coll_b clear", {7'd0, coll_b}, 8'd0);
    old = ref_ba[40];
    sel_b = 1; wen_b = 1; addr_b = 8'd40; wdata_b = old + 8'd1;
    sel_a = 1; oen_a = 1; addr_a = 8'hA8;
    @(negedge clk_a);
    idle_all(); ref_ba[40] = old + 8'd1;
    check("R7 old data a", rdata_a, old);
    check("R7 coll_a set", {6'd0, coll_a, rvalid_a}, 8'h03);
    sel_a = 1; wen_a = 1; addr_a = 8'd50; wdata_a = 8'h99;
    sel_b = 1; oen_b = 1; addr_b = 8'd51;
    @(negedge clk_a);
    idle_all(); ref_ab[50] = 8'h99;
    check("R7 other word data", rdata_b, ref_ab[51]);
    check("R7 other word no coll", {7'd0, coll_b}, 8'd0);
    read_b_chk("R1 after coll test", 8'd50, 8'h99);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    report();
  end

  initial begin
    repeat (3) @(negedge clk_a);
    t_reset();
    rst_a_n = 1; rst_b_n = 1;
    @(negedge clk_a);
    t_fill_a2b();
    t_fill_b2a();
    t_independent();
    t_addr_msb();
    t_write_rules();
    t_idle_outputs();
    t_collision();
    report();
  end
endmodule